// File: doc/BRIEF.md
# Power State and Reset Controller

This block decides which clock domains of a small system run at any moment and when the system leaves reset. It keeps a three-state power machine: Operating (everything clocked), Idle (processor clock gated, peripherals and oscillator still running) and Standby (oscillator stopped, only the timekeeping logic alive). Software moves the machine down with one-cycle request strobes. Hardware moves it back up, through an interrupt request or a rising edge on the wake-up pin.

Three active-low reset pins (power-on, power-fail and user) are merged into one system reset. It asserts at once and releases synchronously. A second reset, driven by the power-on pin alone, serves the timekeeping registers, so the time survives a user reset or a supply dip. Two strap pins are captured while power-on reset is held: one selects the clock source and one selects the boot source. Their values stay frozen until the next power-on reset.

The controller runs on an always-on clock. Every reset sends the machine to Standby, and it stays there until the wake-up pin makes a clean low-to-high transition.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: `pwr_state_o` encodes Standby as 2'b00, Operating as 2'b01 and Idle as 2'b10. In Operating, `cpu_clk_en_o`, `osc_en_o` and `periph_clk_en_o` are all 1. In Idle, `cpu_clk_en_o` is 0 and the other two enables are 1. In Standby, all three enables are 0. The enables change on the same edge as the state.
- R2: In Idle, a high `irq_i` sampled at a clock edge, or a detected wake-up edge, moves the state to Operating at that edge.
- R3: Standby is entered only from Operating. A standby request strobe that arrives while in Idle leaves the state in Idle.
- R4: In Operating, an idle request strobe moves the state to Idle at the sampling edge. If both request strobes are high in the same cycle, Standby is chosen. Request strobes that arrive in Standby have no effect.
- R5: After any reset the state is Standby. When `wake_i` is first sampled high at edge k, the state becomes Operating at edge k+WAKE_STAGES.
- R6: Only rising edges of `wake_i` count. A level held high produces a single wake-up. A line that is already high when reset releases does not count as an edge. `irq_i` does not leave Standby.
- R7: Any of `por_n_i`, `pfail_n_i` or `urst_n_i` going low drives `sys_rst_n_o` low without waiting for a clock. Once all three are high, `sys_rst_n_o` rises at the RST_STAGES-th clock edge.
- R8: `rtc_rst_n_o` follows only `por_n_i`, with the same asynchronous assertion and RST_STAGES-edge release. Power-fail and user resets leave it high.
- R9: `ext_clk_mode_o` (1 selects the external clock, 0 the PLL) and `ext_boot_o` (1 selects external boot, 0 internal ROM) hold the strap pin values sampled at the last edge before `rtc_rst_n_o` releases. After that they ignore the pins and are unaffected by power-fail and user resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| pfail_n_i | input | 1 | Power-fail reset, active low, asynchronous |
| urst_n_i | input | 1 | User reset, active low, asynchronous |
| wake_i | input | 1 | Wake-up pin, asynchronous, rising edge acts |
| irq_i | input | 1 | Pending interrupt request, synchronous level |
| sw_idle_req_i | input | 1 | One-cycle software request to enter Idle |
| sw_stby_req_i | input | 1 | One-cycle software request to enter Standby |
| strap_clk_i | input | 1 | Clock-source strap pin |
| strap_boot_i | input | 1 | Boot-source strap pin |
| sys_rst_n_o | output | 1 | System reset, active low |
| rtc_rst_n_o | output | 1 | Timekeeping register reset, active low |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| pwr_state_o | output | 2 | Current power state |
| ext_clk_mode_o | output | 1 | Latched clock-source selection |
| ext_boot_o | output | 1 | Latched boot-source selection |

## Verification
The bench builds the block with RST_STAGES=3 and WAKE_STAGES=2. The reset release length then differs from the wake synchronizer depth, so a mix-up between the two parameters shows up as a one-cycle timing error in the per-clock comparison. A three-edge release also leaves more than one edge on which the straps are still being captured. That window is where a wrong capture condition is exposed. The stimulus holds the wake-up line high across reset releases and across Idle entries, which puts the edge-only wake rule within reach.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    PS_STBY = 2'b00,
    PS_OPER = 2'b01,
    PS_IDLE = 2'b10
  } pwr_state_e;

  typedef struct packed {
    logic cpu;
    logic osc;
    logic periph;
  } clk_en_t;

  // Clock enables implied by a power state.
  function automatic clk_en_t enables_of(pwr_state_e s);
    clk_en_t e;
    e.cpu    = (s == PS_OPER);
    e.osc    = (s != PS_STBY);
    e.periph = (s != PS_STBY);
    return e;
  endfunction

  // One step of the power machine; standby request outranks idle request.
  function automatic pwr_state_e next_state(pwr_state_e s, logic wake_rise,
                                            logic irq, logic idle_req,
                                            logic stby_req);
    pwr_state_e n;
    n = s;
    case (s)
      PS_STBY: if (wake_rise) n = PS_OPER;
      PS_OPER: begin
        if (stby_req)      n = PS_STBY;
        else if (idle_req) n = PS_IDLE;
      end
      PS_IDLE: if (irq || wake_rise) n = PS_OPER;
      default: n = PS_STBY;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/prc_rst_sync.sv
module prc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

  // R7: once released, the reset stays released while the input stays high
  assert_release_sticky_R7: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    rst_n_o |=> rst_n_o);
endmodule

// File: rtl/prc_wake_edge.sv
module prc_wake_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  // Flops come out of reset high: a line already high is not an edge.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= level;
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~prev_q;

  // R6: a detected edge lasts one cycle, so a held level cannot repeat it
  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rise_o |=> !rise_o);
endmodule

// File: rtl/prc_pwr_fsm.sv
module prc_pwr_fsm
  import prc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       wake_rise_i,
  input  logic       irq_i,
  input  logic       idle_req_i,
  input  logic       stby_req_i,
  output pwr_state_e state_o,
  output clk_en_t    en_o
);
  pwr_state_e st_q, st_d;
  clk_en_t    en_q;
  logic       leave_idle;
  logic       enter_stby;

  assign st_d = next_state(st_q, wake_rise_i, irq_i, idle_req_i, stby_req_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= PS_STBY;
      en_q <= enables_of(PS_STBY);
    end else begin
      st_q <= st_d;
      en_q <= enables_of(st_d);
    end
  end

  assign state_o    = st_q;
  assign en_o       = en_q;
  assign leave_idle = (st_q == PS_IDLE) && (st_d != PS_IDLE);
  assign enter_stby = (st_q != PS_STBY) && (st_d == PS_STBY);

  // R3: Standby is only reached from Operating
  assert_stby_from_oper_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    enter_stby |-> st_q == PS_OPER);
  // R2: Idle exits only to Operating and only on irq or wake edge
  assert_idle_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(st_q) == PS_IDLE && st_q != PS_IDLE) |->
      (st_q == PS_OPER && ($past(irq_i) || $past(wake_rise_i))));
  // R1: processor clock never runs without oscillator and peripherals
  assert_en_nesting_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    en_q.cpu |-> (en_q.osc && en_q.periph));
  // R1: enables agree with the state register in Idle and Standby
  assert_en_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == PS_IDLE) |-> (!en_q.cpu && en_q.periph));
  assert_en_stby_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == PS_STBY) |-> (!en_q.cpu && !en_q.osc && !en_q.periph));
  // R4: requests in Standby do not move the machine
  assert_stby_ignores_req_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == PS_STBY && !wake_rise_i) |=> st_q == PS_STBY);
  // R2: leaving Idle is observable as a named event
  assert_leave_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    leave_idle |=> st_q == PS_OPER);
endmodule

// File: rtl/prc_strap_latch.sv
module prc_strap_latch #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             hold_n_i,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] val_q;

  // Tracks the pins while power-on reset holds, freezes on its release.
  always_ff @(posedge clk_i) begin
    if (!hold_n_i) val_q <= pins_i;
  end

  assign val_o = val_q;
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import prc_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int WAKE_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       pfail_n_i,
  input  logic       urst_n_i,
  input  logic       wake_i,
  input  logic       irq_i,
  input  logic       sw_idle_req_i,
  input  logic       sw_stby_req_i,
  input  logic       strap_clk_i,
  input  logic       strap_boot_i,
  output logic       sys_rst_n_o,
  output logic       rtc_rst_n_o,
  output logic       cpu_clk_en_o,
  output logic       osc_en_o,
  output logic       periph_clk_en_o,
  output logic [1:0] pwr_state_o,
  output logic       ext_clk_mode_o,
  output logic       ext_boot_o
);
  localparam int STRAP_W   = 2;
  localparam int STRAP_CLK = 0;
  localparam int STRAP_BOOT = 1;

  logic               any_rst_n;
  logic               sys_rst_n;
  logic               por_rst_n;
  logic               wake_rise;
  logic [STRAP_W-1:0] strap_pins;
  logic [STRAP_W-1:0] strap_val;
  pwr_state_e         state;
  clk_en_t            en;

  assign any_rst_n = por_n_i & pfail_n_i & urst_n_i;

  prc_rst_sync #(.STAGES(RST_STAGES)) u_sys_rst (
    .clk_i   (clk_i),
    .arst_n_i(any_rst_n),
    .rst_n_o (sys_rst_n)
  );

  prc_rst_sync #(.STAGES(RST_STAGES)) u_rtc_rst (
    .clk_i   (clk_i),
    .arst_n_i(por_n_i),
    .rst_n_o (por_rst_n)
  );

  prc_wake_edge #(.STAGES(WAKE_STAGES)) u_wake (
    .clk_i  (clk_i),
    .rst_n_i(sys_rst_n),
    .pin_i  (wake_i),
    .rise_o (wake_rise)
  );

  prc_pwr_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_n_i    (sys_rst_n),
    .wake_rise_i(wake_rise),
    .irq_i      (irq_i),
    .idle_req_i (sw_idle_req_i),
    .stby_req_i (sw_stby_req_i),
    .state_o    (state),
    .en_o       (en)
  );

  assign strap_pins[STRAP_CLK]  = strap_clk_i;
  assign strap_pins[STRAP_BOOT] = strap_boot_i;

  prc_strap_latch #(.WIDTH(STRAP_W)) u_strap (
    .clk_i   (clk_i),
    .hold_n_i(por_rst_n),
    .pins_i  (strap_pins),
    .val_o   (strap_val)
  );

  assign sys_rst_n_o     = sys_rst_n;
  assign rtc_rst_n_o     = por_rst_n;
  assign cpu_clk_en_o    = en.cpu;
  assign osc_en_o        = en.osc;
  assign periph_clk_en_o = en.periph;
  assign pwr_state_o     = state;
  assign ext_clk_mode_o  = strap_val[STRAP_CLK];
  assign ext_boot_o      = strap_val[STRAP_BOOT];

  // R9: captured straps are frozen once power-on reset has released
  assert_strap_frozen_R9: assert property (@(posedge clk_i) disable iff (!por_rst_n)
    $past(por_rst_n) |-> ($stable(ext_clk_mode_o) && $stable(ext_boot_o)));
  // R8: timekeeping reset active implies system reset active
  assert_rtc_within_sys_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !por_rst_n |-> !sys_rst_n);
  // R5: the machine is in Standby on the first cycle after system reset releases
  assert_stby_after_reset_R5: assert property (@(posedge clk_i) disable iff (!any_rst_n)
    $rose(sys_rst_n) |-> state == PS_STBY);
endmodule

// File: tb/pwr_rst_ctrl_tb_top.sv
module pwr_rst_ctrl_tb_top;
  localparam int RST_ST  = 3;
  localparam int WAKE_ST = 2;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_n = 1'b0, pfail_n = 1'b0, urst_n = 1'b0;
  logic wake = 1'b0, irq = 1'b0, idle_req = 1'b0, stby_req = 1'b0;
  logic s_clk = 1'b1, s_boot = 1'b0;
  logic sys_rst_n, rtc_rst_n, cpu_en, osc_en, per_en, xclk, xboot;
  logic [1:0] pstate;

  pwr_rst_ctrl #(.RST_STAGES(RST_ST), .WAKE_STAGES(WAKE_ST)) dut_i (
    .clk_i(clk), .por_n_i(por_n), .pfail_n_i(pfail_n), .urst_n_i(urst_n),
    .wake_i(wake), .irq_i(irq), .sw_idle_req_i(idle_req), .sw_stby_req_i(stby_req),
    .strap_clk_i(s_clk), .strap_boot_i(s_boot),
    .sys_rst_n_o(sys_rst_n), .rtc_rst_n_o(rtc_rst_n), .cpu_clk_en_o(cpu_en),
    .osc_en_o(osc_en), .periph_clk_en_o(per_en), .pwr_state_o(pstate),
    .ext_clk_mode_o(xclk), .ext_boot_o(xboot)
  );

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: counters for reset release, a sample history
  // for the wake line, an integer state (0 Standby, 1 Operating, 2 Idle).
  int m_sys = 0, m_por = 0, m_state = 0;
  bit hist[$];
  bit m_xclk, m_xboot, sys_busy, por_busy, edge_seen;

  always @(posedge clk) begin
    sys_busy = (m_sys < RST_ST) || !(por_n && pfail_n && urst_n);
    por_busy = (m_por < RST_ST) || !por_n;
    if (sys_busy) begin
      m_state = 0;
      hist.delete();
      for (int i = 0; i <= WAKE_ST; i++) hist.push_back(1'b1);
    end else begin
      edge_seen = hist[WAKE_ST-1] && !hist[WAKE_ST];
      if (m_state == 0 && edge_seen) m_state = 1;
      else if (m_state == 1 && stby_req) m_state = 0;
      else if (m_state == 1 && idle_req) m_state = 2;
      else if (m_state == 2 && (irq || edge_seen)) m_state = 1;
      hist.push_front(wake);
      void'(hist.pop_back());
    end
    if (por_busy) begin
      m_xclk  = s_clk;
      m_xboot = s_boot;
    end
    if (!(por_n && pfail_n && urst_n)) m_sys = 0;
    else if (m_sys < RST_ST) m_sys++;
    if (!por_n) m_por = 0;
    else if (m_por < RST_ST) m_por++;
  end

  // Per-clock comparison, well away from both clock edges.
  always @(posedge clk) begin
    #5;
    if (cmp_on) begin
      chk("R7 sys_rst_n", sys_rst_n, int'(m_sys >= RST_ST));
      chk("R8 rtc_rst_n", rtc_rst_n, int'(m_por >= RST_ST));
      chk("R5 state", pstate, m_state);
      chk("R1 cpu_en", cpu_en, int'(m_state == 1));
      chk("R1 osc_en", osc_en, int'(m_state != 0));
      chk("R1 periph_en", per_en, int'(m_state != 0));
      if (m_por >= RST_ST) begin
        chk("R9 ext_clk_mode", xclk, m_xclk);
        chk("R9 ext_boot", xboot, m_xboot);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_idle();
    idle_req = 1'b1; tick(1); idle_req = 1'b0;
  endtask

  task automatic pulse_stby();
    stby_req = 1'b1; tick(1); stby_req = 1'b0;
  endtask

  task automatic rewake();
    wake = 1'b0; tick(3); wake = 1'b1; tick(WAKE_ST + 2);
  endtask

  initial begin
    tick(4);
    cmp_on = 1'b1;
    tick(1);
    chk("R7 reset sys low", sys_rst_n, 0);
    chk("R8 reset rtc low", rtc_rst_n, 0);
    chk("R5 reset state standby", pstate, 0);

    por_n = 1'b1; pfail_n = 1'b1; urst_n = 1'b1;
    tick(RST_ST + 1);
    s_clk = 1'b0; s_boot = 1'b1;
    tick(3);
    chk("R9 clk strap held", xclk, 1);
    chk("R9 boot strap held", xboot, 0);
    chk("R7 sys released", sys_rst_n, 1);
    chk("R5 waits in standby", pstate, 0);

    irq = 1'b1; tick(3); irq = 1'b0; tick(1);
    chk("R6 irq ignored in standby", pstate, 0);

    wake = 1'b1; tick(WAKE_ST + 2);
    chk("R5 wake edge to operating", pstate, 1);
    tick(5);
    chk("R6 held wake stays operating", pstate, 1);

    pulse_idle();
    chk("R4 idle entered", pstate, 2);
    chk("R1 idle cpu gated", cpu_en, 0);
    chk("R1 idle periph on", per_en, 1);
    pulse_stby(); tick(1);
    chk("R3 standby req ignored in idle", pstate, 2);
    tick(4);
    chk("R6 held wake no second wake", pstate, 2);

    irq = 1'b1; tick(1); irq = 1'b0;
    chk("R2 irq leaves idle", pstate, 1);

    pulse_idle();
    chk("R4 idle again", pstate, 2);
    rewake();
    chk("R2 wake edge leaves idle", pstate, 1);

    idle_req = 1'b1; stby_req = 1'b1; tick(1); idle_req = 1'b0; stby_req = 1'b0;
    chk("R4 standby wins over idle", pstate, 0);
    chk("R1 standby osc off", osc_en, 0);
    pulse_idle(); tick(1);
    chk("R4 idle req ignored in standby", pstate, 0);

    rewake();
    chk("R5 operating again", pstate, 1);
    urst_n = 1'b0; tick(2);
    chk("R7 user reset sys low", sys_rst_n, 0);
    chk("R8 user reset rtc high", rtc_rst_n, 1);
    urst_n = 1'b1; tick(RST_ST + 6);
    chk("R6 wake high across release ignored", pstate, 0);
    chk("R9 clk strap after user reset", xclk, 1);
    chk("R9 boot strap after user reset", xboot, 0);

    rewake();
    pfail_n = 1'b0; tick(2);
    chk("R8 power-fail rtc high", rtc_rst_n, 1);
    chk("R7 power-fail sys low", sys_rst_n, 0);
    pfail_n = 1'b1; tick(RST_ST + 3);

    por_n = 1'b0; tick(3);
    chk("R8 power-on rtc low", rtc_rst_n, 0);
    por_n = 1'b1; tick(RST_ST + 3);
    chk("R9 new clk strap", xclk, 0);
    chk("R9 new boot strap", xboot, 1);
    chk("R5 standby after power-on", pstate, 0);

    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * MAX_CYC);
    bad++;
    total++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule